// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This block lets several cores share a small word-addressed memory through atomic read-modify-write operations. Each requester presents an opcode, an address and a data word. A round-robin arbiter picks one request at a time. The chosen operation reads the word, decides what to write and writes it back in a fixed two-cycle window, and no other request reaches the memory during that window. The response carries the word as it was before the operation, a success flag and the index of the requester it belongs to.

Four primitives are offered: an unconditional swap, test-and-set, fetch-and-increment, and a load-linked / store-conditional pair. The pair is backed by one reservation per requester. Any write to a word breaks every reservation on that word, so a lock-acquire loop built on these operations can retry until it succeeds. A failed attempt reports a clean failure and leaves memory untouched.

Top module: `amo_unit`

## Requirements
- R1: Opcode 3'd0 (swap) writes the request data into the addressed word, returns the previous word and reports success.
- R2: Opcode 3'd1 (test-and-set) writes the request data only when the stored word is zero, and then reports success. On a nonzero word it writes nothing and reports failure. The previous word is returned in both cases.
- R3: Opcode 3'd2 (fetch-and-increment) returns the previous word, stores that word plus one modulo 2^DW and reports success.
- R4: Opcode 3'd3 (load-linked) returns the word, writes nothing, reports success and gives the requester a reservation on that address. This replaces any reservation the requester held before.
- R5: Opcode 3'd4 (store-conditional) writes the request data and reports success only if the requester holds a reservation on that same address. Otherwise it writes nothing and reports failure. It returns the previous word, and the requester's reservation is gone afterwards in both cases.
- R6: Every write to an address, whichever requester makes it, cancels all reservations on that address, including those held by other requesters.
- R7: Opcodes 3'd5 to 3'd7 write nothing, report failure and return the word.
- R8: `req_gnt` is one-hot or zero and only grants a requester whose `req_valid` is high. The winner is the first valid requester in ascending index order, wrapping around, starting after the requester granted last.
- R9: A grant is combinational in the cycle the request is accepted. `resp_valid` pulses for one cycle, visible after the second rising edge after that acceptance, and carries the accepted requester's index. No grant is given in the cycle after a grant.
- R10: While reset is high and after it is released, no grant or response is active until a request arrives. All reservations are cleared, requester 0 has first priority, and memory words start at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NREQ | Request pending, one bit per requester, held until granted |
| req_op | input | NREQ*3 | Opcode per requester |
| req_addr | input | NREQ*AW | Word address per requester |
| req_wdata | input | NREQ*DW | Data word per requester |
| req_gnt | output | NREQ | One-hot acceptance of a request |
| resp_valid | output | 1 | Response strobe |
| resp_id | output | IDW | Requester the response belongs to |
| resp_data | output | DW | Word as it was before the operation |
| resp_ok | output | 1 | Operation succeeded (it wrote, or it was a load-linked) |

## Verification
The bench aims at the reservation corner cases, where a faulty design commits a store-conditional it should have failed:
- a reservation broken by another requester's winning store-conditional or by a plain swap;
- a store-conditional to a different address from the linked one;
- a second store-conditional after a successful one;
- a reservation replaced by a newer load-linked.

It also covers test-and-set on a nonzero word, which a wrong design would overwrite, and increment wraparound at the all-ones word. Simultaneous requests check that grants rotate from the last winner and that no two operations overlap. An overlap would show up as fetch-and-increment responses that repeat a value.

// File: rtl/amo_pkg.sv
package amo_pkg;
  localparam int OPW = 3;

  typedef enum logic [OPW-1:0] {
    OP_SWAP = 3'd0,
    OP_TAS  = 3'd1,
    OP_FINC = 3'd2,
    OP_LL   = 3'd3,
    OP_SC   = 3'd4
  } amo_op_e;
endpackage

// File: rtl/amo_rr_arb.sv
module amo_rr_arb #(
  parameter int NREQ = 4,
  parameter int IDW  = $clog2(NREQ)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [NREQ-1:0] req,
  output logic [NREQ-1:0] gnt,
  output logic [IDW-1:0]  gnt_id
);
  logic [IDW-1:0] last_q;
  logic           found;

  // scan from the requester after the last winner, wrapping
  always_comb begin
    gnt    = '0;
    gnt_id = '0;
    found  = 1'b0;
    for (int k = 1; k <= NREQ; k++) begin
      int idx;
      idx = (int'(last_q) + k) % NREQ;
      if (!found && en && req[idx]) begin
        found       = 1'b1;
        gnt[idx]    = 1'b1;
        gnt_id      = IDW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        last_q <= IDW'(NREQ - 1);
    else if (found) last_q <= gnt_id;
  end
endmodule

// File: rtl/amo_alu.sv
module amo_alu import amo_pkg::*; #(
  parameter int DW = 8
) (
  input  logic [OPW-1:0] op,
  input  logic [DW-1:0]  old_val,
  input  logic [DW-1:0]  wdata,
  input  logic           resv_hit,
  output logic [DW-1:0]  new_val,
  output logic           we,
  output logic           ok
);
  always_comb begin
    new_val = wdata;
    we      = 1'b0;
    ok      = 1'b0;
    case (amo_op_e'(op))
      OP_SWAP: begin we = 1'b1; ok = 1'b1; end
      OP_TAS: begin
        we = (old_val == '0);
        ok = (old_val == '0);
      end
      OP_FINC: begin
        new_val = old_val + DW'(1);
        we      = 1'b1;
        ok      = 1'b1;
      end
      OP_LL:   ok = 1'b1;
      OP_SC: begin we = resv_hit; ok = resv_hit; end
      default: begin we = 1'b0; ok = 1'b0; end
    endcase
  end
endmodule

// File: rtl/amo_resv.sv
module amo_resv #(
  parameter int NREQ = 4,
  parameter int AW   = 4,
  parameter int IDW  = $clog2(NREQ)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           upd,
  input  logic [IDW-1:0] id,
  input  logic [AW-1:0]  addr,
  input  logic           is_ll,
  input  logic           is_sc,
  input  logic           wrote,
  output logic           hit
);
  logic [NREQ-1:0] rv_q;
  logic [AW-1:0]   ra_q [NREQ];

  assign hit = rv_q[id] && (ra_q[id] == addr);

  generate
    for (genvar i = 0; i < NREQ; i++) begin : g_slot
      always_ff @(posedge clk) begin
        if (rst) begin
          rv_q[i] <= 1'b0;
          ra_q[i] <= '0;
        end else if (upd) begin
          if (wrote && rv_q[i] && ra_q[i] == addr) rv_q[i] <= 1'b0;
          if (is_sc && id == IDW'(i))              rv_q[i] <= 1'b0;
          if (is_ll && id == IDW'(i)) begin
            rv_q[i] <= 1'b1;
            ra_q[i] <= addr;
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/amo_unit.sv
module amo_unit import amo_pkg::*; #(
  parameter  int NREQ = 4,
  parameter  int AW   = 4,
  parameter  int DW   = 8,
  localparam int IDW  = $clog2(NREQ)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NREQ-1:0]     req_valid,
  input  logic [NREQ*OPW-1:0] req_op,
  input  logic [NREQ*AW-1:0]  req_addr,
  input  logic [NREQ*DW-1:0]  req_wdata,
  output logic [NREQ-1:0]     req_gnt,
  output logic                resp_valid,
  output logic [IDW-1:0]      resp_id,
  output logic [DW-1:0]       resp_data,
  output logic                resp_ok
);
  localparam int DEPTH = 1 << AW;

  logic           busy;
  logic [IDW-1:0] gnt_id;
  logic [OPW-1:0] op_q;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  wdata_q;
  logic [IDW-1:0] id_q;
  logic [DW-1:0]  rd_q;
  logic [DW-1:0]  new_val;
  logic           alu_we, alu_ok, resv_hit, wr_en;
  logic [AW-1:0]  sel_addr;

  logic [DW-1:0]  mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  amo_rr_arb #(.NREQ(NREQ), .IDW(IDW)) u_arb (
    .clk    (clk),
    .rst    (rst),
    .en     (!busy && !rst),
    .req    (req_valid),
    .gnt    (req_gnt),
    .gnt_id (gnt_id)
  );

  assign sel_addr = req_addr[int'(gnt_id)*AW +: AW];

  // read phase: memory read of the winner's address lands in rd_q
  // write phase: one cycle later, the modified word is written back
  always_ff @(posedge clk) begin
    if (wr_en) mem[addr_q] <= new_val;
    rd_q <= mem[sel_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      op_q       <= '0;
      addr_q     <= '0;
      wdata_q    <= '0;
      id_q       <= '0;
      resp_valid <= 1'b0;
      resp_id    <= '0;
      resp_data  <= '0;
      resp_ok    <= 1'b0;
    end else begin
      resp_valid <= 1'b0;
      if (busy) begin
        busy       <= 1'b0;
        resp_valid <= 1'b1;
        resp_id    <= id_q;
        resp_data  <= rd_q;
        resp_ok    <= alu_ok;
      end else if (|req_gnt) begin
        busy    <= 1'b1;
        op_q    <= req_op[int'(gnt_id)*OPW +: OPW];
        addr_q  <= sel_addr;
        wdata_q <= req_wdata[int'(gnt_id)*DW +: DW];
        id_q    <= gnt_id;
      end
    end
  end

  amo_alu #(.DW(DW)) u_alu (
    .op       (op_q),
    .old_val  (rd_q),
    .wdata    (wdata_q),
    .resv_hit (resv_hit),
    .new_val  (new_val),
    .we       (alu_we),
    .ok       (alu_ok)
  );

  assign wr_en = busy && alu_we;

  amo_resv #(.NREQ(NREQ), .AW(AW), .IDW(IDW)) u_resv (
    .clk   (clk),
    .rst   (rst),
    .upd   (busy),
    .id    (id_q),
    .addr  (addr_q),
    .is_ll (op_q == OP_LL),
    .is_sc (op_q == OP_SC),
    .wrote (wr_en),
    .hit   (resv_hit)
  );
endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk #(
  parameter int NREQ = 4,
  parameter int IDW  = 2
) (
  input logic            clk,
  input logic            rst,
  input logic [NREQ-1:0] req_valid,
  input logic [NREQ-1:0] req_gnt,
  input logic            resp_valid,
  input logic [IDW-1:0]  resp_id,
  input logic            resp_ok,
  input logic            wr_en
);
  // R8
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(req_gnt));

  // R8
  gnt_to_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (req_gnt & ~req_valid) == '0);

  // R9
  gnt_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (|req_gnt) |=> (req_gnt == '0));

  // R9
  resp_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (|req_gnt) |-> ##2 resp_valid);

  // R9
  resp_owner_chk: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> ($past(req_gnt, 2) == (NREQ'(1) << resp_id)));

  // R5 (also R2, R7): a failed operation wrote nothing
  fail_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_ok) |-> !$past(wr_en));
endmodule

bind amo_unit amo_unit_chk #(.NREQ(NREQ), .IDW(IDW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_gnt    (req_gnt),
  .resp_valid (resp_valid),
  .resp_id    (resp_id),
  .resp_ok    (resp_ok),
  .wr_en      (wr_en)
);

// File: tb/amo_unit_tb.sv
module amo_unit_tb;
  localparam int NREQ = 4;
  localparam int AW   = 4;
  localparam int DW   = 8;
  localparam int IDW  = 2;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [NREQ-1:0]     req_valid = '0;
  logic [NREQ*3-1:0]   req_op = '0;
  logic [NREQ*AW-1:0]  req_addr = '0;
  logic [NREQ*DW-1:0]  req_wdata = '0;
  logic [NREQ-1:0]     req_gnt;
  logic                resp_valid;
  logic [IDW-1:0]      resp_id;
  logic [DW-1:0]       resp_data;
  logic                resp_ok;

  always #2 clk = ~clk;

  amo_unit #(.NREQ(NREQ), .AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_gnt(req_gnt),
    .resp_valid(resp_valid), .resp_id(resp_id), .resp_data(resp_data),
    .resp_ok(resp_ok)
  );

  int errors = 0;
  int checks = 0;

  // response log
  int rcount = 0;
  int rlog_id [1024];
  int rlog_d  [1024];
  bit rlog_ok [1024];
  always @(negedge clk) begin
    if (resp_valid && rcount < 1024) begin
      rlog_id[rcount] = int'(resp_id);
      rlog_d[rcount]  = int'(resp_data);
      rlog_ok[rcount] = resp_ok;
      rcount = rcount + 1;
    end
  end

  // reference model
  int m_mem [16];
  bit m_rv  [NREQ];
  int m_ra  [NREQ];

  task automatic chk(input bit cond, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic model_step(input int id, input int op, input int addr,
                            input int wd, output int ed, output bit eok);
    int old;
    bit hit, we;
    int nv;
    old = m_mem[addr];
    hit = m_rv[id] && (m_ra[id] == addr);
    we  = 1'b0;
    nv  = wd;
    eok = 1'b0;
    case (op)
      0: begin we = 1; eok = 1; end
      1: begin we = (old == 0); eok = we; end
      2: begin nv = (old + 1) % 256; we = 1; eok = 1; end
      3: eok = 1;
      4: begin we = hit; eok = hit; end
      default: ;
    endcase
    if (we) begin
      m_mem[addr] = nv;
      for (int i = 0; i < NREQ; i++)
        if (m_ra[i] == addr) m_rv[i] = 1'b0;
    end
    if (op == 4) m_rv[id] = 1'b0;
    if (op == 3) begin m_rv[id] = 1'b1; m_ra[id] = addr; end
    ed = old;
  endtask

  task automatic drive(input int id, input int op, input int addr, input int wd);
    req_op[id*3 +: 3]     = 3'(op);
    req_addr[id*AW +: AW] = AW'(addr);
    req_wdata[id*DW +: DW]= DW'(wd);
    req_valid[id]         = 1'b1;
  endtask

  task automatic do_op(input int id, input int op, input int addr,
                       input int wd, input string rq);
    int ed, n0;
    bit eok;
    model_step(id, op, addr, wd, ed, eok);
    @(negedge clk);
    drive(id, op, addr, wd);
    #1;
    while (!req_gnt[id]) begin @(negedge clk); #1; end
    n0 = rcount;
    @(negedge clk);
    req_valid[id] = 1'b0;
    @(negedge clk);
    #1;
    chk(rcount == n0 + 1, "R9", "response count at fixed latency", rcount - n0, 1);
    if (rcount == n0 + 1) begin
      chk(rlog_id[n0] == id, rq, "resp_id", rlog_id[n0], id);
      chk(rlog_d[n0] == ed, rq, "resp_data", rlog_d[n0], ed);
      chk(rlog_ok[n0] == eok, rq, "resp_ok", int'(rlog_ok[n0]), int'(eok));
    end
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int exp_order [4];
    int exp_d [4];
    bit exp_ok [4];
    int n0, w, lf;
    for (int i = 0; i < 16; i++) m_mem[i] = 0;
    for (int i = 0; i < NREQ; i++) begin m_rv[i] = 0; m_ra[i] = 0; end
    exp_order[0] = 1; exp_order[1] = 2; exp_order[2] = 3; exp_order[3] = 0;

    // R10 reset state
    drive(2, 0, 1, 9);
    repeat (3) @(negedge clk);
    #1;
    chk(req_gnt == '0, "R10", "no grant in reset", int'(req_gnt), 0);
    chk(resp_valid == 1'b0, "R10", "no response in reset", int'(resp_valid), 0);
    req_valid = '0;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    chk(req_gnt == '0, "R10", "idle grant after reset", int'(req_gnt), 0);
    chk(resp_valid == 1'b0, "R10", "idle response after reset", int'(resp_valid), 0);

    // R3 first access, memory starts at zero (R10)
    do_op(0, 2, 7, 0, "R3");

    // R8 rotation with all requesters contending
    n0 = rcount;
    @(negedge clk);
    for (int i = 0; i < NREQ; i++) drive(i, 2, 7, 0);
    #1;
    for (int k = 0; k < 4; k++) begin
      while (req_gnt == '0) begin @(negedge clk); #1; end
      w = -1;
      for (int i = 0; i < NREQ; i++) if (req_gnt[i]) w = i;
      chk(w == exp_order[k], "R8", "round-robin winner", w, exp_order[k]);
      model_step(w < 0 ? 0 : w, 2, 7, 0, exp_d[k], exp_ok[k]);
      @(negedge clk);
      if (w >= 0) req_valid[w] = 1'b0;
      #1;
      chk(req_gnt == '0, "R9", "no grant in write cycle", int'(req_gnt), 0);
    end
    @(negedge clk); #1;
    chk(rcount == n0 + 4, "R9", "responses from contention", rcount - n0, 4);
    for (int k = 0; k < 4; k++) begin
      chk(rlog_id[n0+k] == exp_order[k], "R8", "response order", rlog_id[n0+k], exp_order[k]);
      chk(rlog_d[n0+k] == exp_d[k], "R3", "serialized increment", rlog_d[n0+k], exp_d[k]);
    end

    // R1 swap
    do_op(1, 0, 5, 8'hFF, "R1");
    do_op(2, 0, 5, 8'hFF, "R1");
    // R3 wraparound
    do_op(3, 2, 5, 0, "R3");
    do_op(3, 3, 5, 0, "R3");
    // R2 test-and-set on zero then nonzero
    do_op(0, 1, 2, 8'hA5, "R2");
    do_op(1, 1, 2, 8'h3C, "R2");
    do_op(1, 3, 2, 0, "R2");
    // R5 basic pair, then repeat SC fails
    do_op(0, 3, 3, 0, "R4");
    do_op(0, 4, 3, 8'h11, "R5");
    do_op(0, 4, 3, 8'h22, "R5");
    do_op(0, 4, 9, 8'h22, "R5");
    // R6 competing pairs
    do_op(0, 3, 4, 0, "R4");
    do_op(1, 3, 4, 0, "R4");
    do_op(1, 4, 4, 8'h44, "R6");
    do_op(0, 4, 4, 8'h55, "R6");
    do_op(2, 3, 4, 0, "R4");
    do_op(3, 0, 4, 8'h66, "R6");
    do_op(2, 4, 4, 8'h77, "R6");
    // R5 different address
    do_op(1, 3, 4, 0, "R4");
    do_op(1, 4, 5, 8'h12, "R5");
    // R4 replacement
    do_op(2, 3, 6, 0, "R4");
    do_op(2, 3, 8, 0, "R4");
    do_op(2, 4, 6, 8'h34, "R4");
    do_op(2, 3, 8, 0, "R4");
    do_op(2, 4, 8, 8'h56, "R4");
    do_op(2, 3, 8, 0, "R4");
    // R7 unused opcodes
    do_op(3, 6, 8, 8'h99, "R7");
    do_op(3, 5, 8, 8'h98, "R7");
    do_op(3, 7, 8, 8'h97, "R7");
    do_op(3, 3, 8, 0, "R7");

    // mixed sweep over a small address set
    lf = 16'hACE1;
    for (int n = 0; n < 300; n++) begin
      int id, op, ad, wd;
      lf = ((lf << 1) | (((lf >> 15) ^ (lf >> 13) ^ (lf >> 12) ^ (lf >> 10)) & 1)) & 16'hFFFF;
      id = lf % NREQ;
      op = (lf >> 2) % 6;
      ad = (lf >> 5) % 4;
      wd = ((lf >> 8) & 3) == 0 ? 0 : ((lf >> 7) & 255);
      do_op(id, op, ad, wd, "R6");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule